// File: doc/BRIEF.md
# Load/Store Memory Address Queue with Load Bypass

This block sits between address translation and the memory port. Translated load and store addresses arrive on two separate push interfaces and wait in two separate first-in first-out queues. A store address may only go to memory once its data item is waiting at the head of the external store data queue. When the block sends a store, it pops that data item. A load does not have to wait behind stores that are still missing their data. It is sent ahead of them unless one of those older stores writes the same doubleword.

A single request/grant memory port carries both classes. When a load with no conflict is available, it wins over a ready store. A load that conflicts with an older store leaves the port to the stores until the matching store has drained. Loads behind the blocked load wait as well, because loads stay in program order. Each queue raises a full flag to throttle the address generator. A flush input empties both queues in one cycle so that the pipeline can recover from a trap.

Top module: `ldst_addr_queue`

## Requirements
- R1: After reset both queues are empty, mem_req_o is 0, and both full flags are 0.
- R2: Loads are sent to memory in the order they were pushed, and so are stores. A grant that no pushed entry accounts for never occurs.
- R3: A store is requested only while sd_avail_i is 1. sd_pop_o is 1 exactly in the cycle in which a store request is granted.
- R4: A load at the head of its queue is sent ahead of older stores that are waiting for data, provided its doubleword address (bits 31:3) matches none of them.
- R5: A load whose bits 31:3 equal those of any older pending store is held until every such store has been granted. Loads behind it are held too. A store pushed in the same cycle as the load counts as older. A store pushed after the load does not hold it.
- R6: When a non-conflicting load and a ready store are both available, the load is requested first (mem_we_o = 0).
- R7: A full flag is 1 when its queue holds DEPTH (8) entries. A push into a full queue is dropped.
- R8: flush_i empties both queues at the next clock edge. Pushes in the flush cycle are dropped, and no request is made in that cycle.
- R9: An entry pushed at a clock edge can be requested in the cycle that follows. A request without a grant keeps its entry in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empties both queues |
| ld_valid_i | input | 1 | Pushes a load address |
| ld_addr_i | input | 32 | Translated load byte address |
| ld_full_o | output | 1 | Load queue full |
| st_valid_i | input | 1 | Pushes a store address |
| st_addr_i | input | 32 | Translated store byte address |
| st_full_o | output | 1 | Store queue full |
| sd_avail_i | input | 1 | Store data queue head holds data |
| sd_pop_o | output | 1 | Pops the store data queue head |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | 32 | Request address |
| mem_gnt_i | input | 1 | Memory accepts the request |

## Verification
An address pushed at a clock edge appears on the memory port in the next cycle. The request comes out combinationally from the queue heads, so a grant is seen in the same cycle it is given. When a store is granted, the conflict it caused is cleared at that edge, and the held load can be requested one cycle later. The bench drives inputs on the falling edge. A monitor samples the port just before each rising edge, and on every grant it compares the request against the next entry in an expected-order list. The driver fills that list from the requirements before it releases the grant. Cycles in which nothing may leave are checked by observing that mem_req_o is low.

// File: rtl/laq_pkg.sv
package laq_pkg;
  localparam int unsigned LAQ_ADDR_W = 32;
  localparam int unsigned LAQ_DEPTH  = 8;
  localparam int unsigned LAQ_DW_LSB = 3;
  typedef enum logic {OP_LD = 1'b0, OP_ST = 1'b1} laq_op_e;
endpackage

// File: rtl/laq_fifo.sv
module laq_fifo #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      push_i,
  input  logic [AW-1:0]             data_i,
  input  logic                      pop_i,
  output logic                      full_o,
  output logic                      empty_o,
  output logic [AW-1:0]             head_o,
  output logic [DEPTH-1:0][AW-1:0]  ent_o,
  output logic [DEPTH-1:0]          vld_o,
  output logic [PW-1:0]             wptr_o,
  output logic [PW-1:0]             rptr_o
);
  logic [DEPTH-1:0][AW-1:0] mem_q;
  logic [DEPTH-1:0]         vld_q;
  logic [PW-1:0]            wptr_q, rptr_q;
  logic [CW-1:0]            cnt_q;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
    end else begin
      if (push_i) wptr_q <= inc(wptr_q);
      if (pop_i)  rptr_q <= inc(rptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
      for (int i = 0; i < DEPTH; i++) begin
        if (push_i && wptr_q == PW'(i))     vld_q[i] <= 1'b1;
        else if (pop_i && rptr_q == PW'(i)) vld_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (push_i) mem_q[wptr_q] <= data_i;
  end

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rptr_q];
  assign ent_o   = mem_q;
  assign vld_o   = vld_q;
  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
endmodule

// File: rtl/laq_dep_track.sv
module laq_dep_track #(
  parameter int unsigned AW     = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DW_LSB = 3,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      ld_push_i,
  input  logic [PW-1:0]             ld_wptr_i,
  input  logic [PW-1:0]             ld_rptr_i,
  input  logic [AW-1:0]             ld_addr_i,
  input  logic [DEPTH-1:0][AW-1:0]  st_ent_i,
  input  logic [DEPTH-1:0]          st_vld_i,
  input  logic                      st_push_i,
  input  logic [PW-1:0]             st_wptr_i,
  input  logic [AW-1:0]             st_addr_i,
  input  logic                      st_pop_i,
  input  logic [PW-1:0]             st_rptr_i,
  output logic                      block_o
);
  // row = load slot, column = store slot it must wait for
  logic [DEPTH-1:0][DEPTH-1:0] dep_q;
  logic [DEPTH-1:0]            hit;

  for (genvar j = 0; j < DEPTH; j++) begin : g_hit
    assign hit[j] =
      (st_vld_i[j] && st_ent_i[j][AW-1:DW_LSB] == ld_addr_i[AW-1:DW_LSB]) ||
      (st_push_i && st_wptr_i == PW'(j) &&
       st_addr_i[AW-1:DW_LSB] == ld_addr_i[AW-1:DW_LSB]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dep_q <= '0;
    else if (clr_i) dep_q <= '0;
    else begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (ld_push_i && ld_wptr_i == PW'(i))
            dep_q[i][j] <= hit[j] && !(st_pop_i && st_rptr_i == PW'(j));
          else if (st_pop_i && st_rptr_i == PW'(j))
            dep_q[i][j] <= 1'b0;
        end
      end
    end
  end

  assign block_o = |dep_q[ld_rptr_i];
endmodule

// File: rtl/laq_port_arb.sv
module laq_port_arb (
  input  logic ld_rdy_i,
  input  logic st_rdy_i,
  input  logic flush_i,
  input  logic gnt_i,
  output logic req_o,
  output logic we_o,
  output logic ld_pop_o,
  output logic st_pop_o
);
  import laq_pkg::*;
  laq_op_e sel;

  always_comb begin
    sel   = ld_rdy_i ? OP_LD : OP_ST;
    req_o = !flush_i && (ld_rdy_i || st_rdy_i);
    we_o  = (sel == OP_ST);
  end

  assign ld_pop_o = req_o && gnt_i && (sel == OP_LD);
  assign st_pop_o = req_o && gnt_i && (sel == OP_ST);
endmodule

// File: rtl/ldst_addr_queue.sv
module ldst_addr_queue #(
  parameter int unsigned AW     = laq_pkg::LAQ_ADDR_W,
  parameter int unsigned DEPTH  = laq_pkg::LAQ_DEPTH,
  parameter int unsigned DW_LSB = laq_pkg::LAQ_DW_LSB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_full_o,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  output logic          st_full_o,
  input  logic          sd_avail_i,
  output logic          sd_pop_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic ld_full, ld_empty, st_full, st_empty;
  logic ld_push, st_push, ld_pop, st_pop, ld_block;
  logic [AW-1:0] ld_head, st_head;
  logic [DEPTH-1:0][AW-1:0] ld_ent, st_ent;
  logic [DEPTH-1:0] ld_vld, st_vld;
  logic [PW-1:0] ld_wptr, ld_rptr, st_wptr, st_rptr;

  assign ld_push = ld_valid_i && !ld_full && !flush_i;
  assign st_push = st_valid_i && !st_full && !flush_i;

  laq_fifo #(.AW(AW), .DEPTH(DEPTH)) u_ldq (
    .clk_i, .rst_ni, .clr_i(flush_i), .push_i(ld_push), .data_i(ld_addr_i),
    .pop_i(ld_pop), .full_o(ld_full), .empty_o(ld_empty), .head_o(ld_head),
    .ent_o(ld_ent), .vld_o(ld_vld), .wptr_o(ld_wptr), .rptr_o(ld_rptr)
  );

  laq_fifo #(.AW(AW), .DEPTH(DEPTH)) u_stq (
    .clk_i, .rst_ni, .clr_i(flush_i), .push_i(st_push), .data_i(st_addr_i),
    .pop_i(st_pop), .full_o(st_full), .empty_o(st_empty), .head_o(st_head),
    .ent_o(st_ent), .vld_o(st_vld), .wptr_o(st_wptr), .rptr_o(st_rptr)
  );

  laq_dep_track #(.AW(AW), .DEPTH(DEPTH), .DW_LSB(DW_LSB)) u_dep (
    .clk_i, .rst_ni, .clr_i(flush_i),
    .ld_push_i(ld_push), .ld_wptr_i(ld_wptr), .ld_rptr_i(ld_rptr),
    .ld_addr_i(ld_addr_i), .st_ent_i(st_ent), .st_vld_i(st_vld),
    .st_push_i(st_push), .st_wptr_i(st_wptr), .st_addr_i(st_addr_i),
    .st_pop_i(st_pop), .st_rptr_i(st_rptr), .block_o(ld_block)
  );

  laq_port_arb u_arb (
    .ld_rdy_i(!ld_empty && !ld_block),
    .st_rdy_i(!st_empty && sd_avail_i),
    .flush_i, .gnt_i(mem_gnt_i),
    .req_o(mem_req_o), .we_o(mem_we_o),
    .ld_pop_o(ld_pop), .st_pop_o(st_pop)
  );

  assign mem_addr_o = mem_we_o ? st_head : ld_head;
  assign sd_pop_o   = st_pop;
  assign ld_full_o  = ld_full;
  assign st_full_o  = st_full;

  logic unused_ok;
  assign unused_ok = ^{ld_ent, ld_vld};
endmodule

// File: rtl/laq_chk.sv
module laq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic flush_i,
  input logic ld_full_o,
  input logic st_full_o,
  input logic sd_avail_i,
  input logic sd_pop_o,
  input logic mem_req_o,
  input logic mem_we_o,
  input logic mem_gnt_i,
  input logic ld_block
);
  // R3
  st_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> sd_avail_i);
  // R3
  sd_pop_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_pop_o |-> mem_req_o && mem_we_o && mem_gnt_i);
  // R5
  blocked_ld_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_block && mem_req_o |-> mem_we_o);
  // R7
  ld_full_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_full_o && !flush_i && !(mem_req_o && mem_gnt_i && !mem_we_o) |=> ld_full_o);
  // R7
  st_full_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_full_o && !flush_i && !(mem_req_o && mem_gnt_i && mem_we_o) |=> st_full_o);
  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !mem_req_o && !ld_full_o && !st_full_o);
  // R8
  flush_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !mem_req_o);
endmodule

bind ldst_addr_queue laq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
  .ld_full_o(ld_full_o), .st_full_o(st_full_o),
  .sd_avail_i(sd_avail_i), .sd_pop_o(sd_pop_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_gnt_i(mem_gnt_i),
  .ld_block(ld_block)
);

// File: tb/sim_ldst_addr_queue.sv
`timescale 1ns/1ps
module sim_ldst_addr_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, ld_v = 1'b0, st_v = 1'b0, sd_av = 1'b0, gnt = 1'b0;
  logic [31:0] ld_a = '0, st_a = '0;
  logic ld_full, st_full, sd_pop, req, we;
  logic [31:0] maddr;
  int vecs = 0, errs = 0;
  bit done = 0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ldst_addr_queue u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .ld_valid_i(ld_v), .ld_addr_i(ld_a), .ld_full_o(ld_full),
    .st_valid_i(st_v), .st_addr_i(st_a), .st_full_o(st_full),
    .sd_avail_i(sd_av), .sd_pop_o(sd_pop),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(maddr), .mem_gnt_i(gnt)
  );

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] expv);
    vecs++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: sample just before the rising edge
  initial forever begin
    @(negedge clk); #4;
    if (rst_n && req && gnt) begin
      if (exp_q.size() == 0) chk("R2", {we, maddr}, 33'h1_ffff_ffff);
      else begin
        string t;
        logic [32:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {we, maddr}, e);
        chk("R3", {32'd0, sd_pop}, {32'd0, we});
      end
    end
  end

  task automatic expect_op(input logic st, input logic [31:0] a, input string tag);
    exp_q.push_back({st, a});
    tag_q.push_back(tag);
  endtask

  task automatic push_ld(input logic [31:0] a);
    @(negedge clk); ld_v = 1'b1; ld_a = a;
    @(negedge clk); ld_v = 1'b0;
  endtask

  task automatic push_st(input logic [31:0] a);
    @(negedge clk); st_v = 1'b1; st_a = a;
    @(negedge clk); st_v = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_chk(input string tag);
    wait_cyc(12);
    chk(tag, {32'd0, exp_q.size() != 0}, 33'd0);
    exp_q.delete(); tag_q.delete();
    gnt = 1'b0; sd_av = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    #4 chk("R1", {30'd0, req, ld_full, st_full}, 33'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1 chk("R1", {30'd0, req, ld_full, st_full}, 33'd0);

    // R4: loads overtake a store waiting for data
    push_st(32'h0000_0100);
    push_ld(32'h0000_0200);
    push_ld(32'h0000_0300);
    expect_op(1'b0, 32'h0000_0200, "R4");
    expect_op(1'b0, 32'h0000_0300, "R2");
    gnt = 1'b1;
    wait_cyc(4);
    #1 chk("R3", {32'd0, req}, 33'd0);
    expect_op(1'b1, 32'h0000_0100, "R3");
    sd_av = 1'b1;
    drain_chk("R4");

    // R5: doubleword conflict holds this load and the next one
    push_st(32'h0000_1008);
    push_ld(32'h0000_100F);
    push_ld(32'h0000_2000);
    gnt = 1'b1;
    wait_cyc(4);
    #1 chk("R5", {32'd0, req}, 33'd0);
    expect_op(1'b1, 32'h0000_1008, "R5");
    expect_op(1'b0, 32'h0000_100F, "R5");
    expect_op(1'b0, 32'h0000_2000, "R2");
    sd_av = 1'b1;
    drain_chk("R5");

    // R5: different doubleword, no conflict
    push_st(32'h0000_1008);
    push_ld(32'h0000_1010);
    expect_op(1'b0, 32'h0000_1010, "R4");
    gnt = 1'b1;
    wait_cyc(3);
    expect_op(1'b1, 32'h0000_1008, "R3");
    sd_av = 1'b1;
    drain_chk("R4");

    // R5: younger store does not hold an older load
    push_ld(32'h0000_0500);
    push_st(32'h0000_0500);
    expect_op(1'b0, 32'h0000_0500, "R5");
    expect_op(1'b1, 32'h0000_0500, "R2");
    sd_av = 1'b1; gnt = 1'b1;
    drain_chk("R5");

    // R5: same-cycle store counts as older
    @(negedge clk); ld_v = 1'b1; st_v = 1'b1; ld_a = 32'h700; st_a = 32'h704;
    @(negedge clk); ld_v = 1'b0; st_v = 1'b0;
    expect_op(1'b1, 32'h0000_0704, "R5");
    expect_op(1'b0, 32'h0000_0700, "R5");
    sd_av = 1'b1; gnt = 1'b1;
    drain_chk("R5");

    // R6: non-conflicting load before ready store
    push_st(32'h0000_0040);
    push_st(32'h0000_0048);
    push_ld(32'h0000_0080);
    expect_op(1'b0, 32'h0000_0080, "R6");
    expect_op(1'b1, 32'h0000_0040, "R2");
    expect_op(1'b1, 32'h0000_0048, "R2");
    sd_av = 1'b1;
    wait_cyc(2);
    #1 chk("R9", {we, maddr}, {1'b0, 32'h0000_0080});
    gnt = 1'b1;
    drain_chk("R6");

    // R7: fill both queues, extra push dropped
    for (int i = 0; i < 8; i++) push_ld(32'h1_0000 + 32'(i) * 8);
    for (int i = 0; i < 8; i++) push_st(32'h2_0000 + 32'(i) * 8);
    #1 chk("R7", {31'd0, ld_full, st_full}, 33'd3);
    push_ld(32'h000D_EAD0);
    push_st(32'h000B_EEF0);
    #1 chk("R7", {31'd0, ld_full, st_full}, 33'd3);
    for (int i = 0; i < 8; i++) expect_op(1'b0, 32'h1_0000 + 32'(i) * 8, "R7");
    for (int i = 0; i < 8; i++) expect_op(1'b1, 32'h2_0000 + 32'(i) * 8, "R7");
    sd_av = 1'b1; gnt = 1'b1;
    wait_cyc(20);
    #1 chk("R7", {32'd0, req}, 33'd0);
    drain_chk("R7");

    // R8: flush drops queued and same-cycle pushes
    push_ld(32'h0000_0010);
    push_st(32'h0000_0020);
    sd_av = 1'b1;
    @(negedge clk); flush = 1'b1; ld_v = 1'b1; ld_a = 32'h30;
    #1 chk("R8", {32'd0, req}, 33'd0);
    @(negedge clk); flush = 1'b0; ld_v = 1'b0;
    #1 chk("R8", {31'd0, req, ld_full}, 33'd0);
    gnt = 1'b1;
    wait_cyc(4);
    #1 chk("R8", {32'd0, req}, 33'd0);
    drain_chk("R8");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule